// File: doc/BRIEF.md
# Double to Half Float Converter

This unit narrows one IEEE-754 binary64 operand to binary16. It rounds under a selectable direction. The 16-bit value is placed in the low bits of a 64-bit result word whose other bits are zero. A second 64-bit result word is always zero. Alongside the result it reports several status bits: invalid caused by a signaling NaN, overflow, underflow, inexact, a "rounded up" bit, a "fraction inexact" bit and a 5-bit class code of the result. An invalid-trap enable input suppresses the result write, the class code and the rounding status whenever a signaling NaN arrives while it is set.

Operands enter through a valid/ready handshake. One register stage holds the result, which leaves through a second valid/ready handshake. The input accepts a new operand when the output slot is empty or is being drained in the same cycle (`in_ready = !out_valid || out_ready`). While `out_valid` is high and `out_ready` is low, every output stays unchanged. One operand per cycle flows through when the consumer never stalls. All other inputs (mode, trap enable) are sampled together with the operand.

Top module: `dh_convert`

## Requirements
- R1: The result is the operand rounded to binary16 under `in_rmode`: 00 nearest-even, 01 toward zero, 10 toward +infinity, 11 toward -infinity. Zeros and infinities keep their sign. `out_inx` is 1 when the rounded value differs from the operand.
- R2: `out_lo[15:0]` carries the binary16 value; `out_lo[63:16]` and all of `out_hi` are zero.
- R3: A NaN operand yields a NaN with the sign kept, fraction bit 9 set to 1 and fraction bits 8..0 copied from operand fraction bits 50..42. `out_snan` is 1 exactly when the operand is a NaN whose fraction bit 51 is 0.
- R4: When the rounded magnitude would reach 65520 or above, `out_ovf` and `out_inx` are 1. The result is then infinity in nearest mode and when rounding away from zero in that sign's direction; otherwise it is 0x7BFF with the sign applied.
- R5: Values below 2^-14 (tiny before rounding) are denormalised before rounding. A carry out of the largest subnormal gives 0x0400. `out_unf` is 1 when the operand is tiny and the result is inexact.
- R6: When `in_trap_en` is 1 and `out_snan` would be 1, `out_we` is 0 and `out_lo`, `out_cls`, `out_rup` and `out_finx` are 0. Otherwise `out_we` is 1.
- R7: Without a trap, `out_rup` is 1 when rounding raised the magnitude of a finite result, or when an overflow produced infinity.
- R8: `out_finx` equals `out_inx` when there is no trap, and is 0 under a trap.
- R9: Without a trap, `out_cls` encodes the result: quiet NaN 10001, -inf 01001, +inf 00101, -normal 01000, +normal 00100, -subnormal 11000, +subnormal 10100, -zero 10010, +zero 00010.
- R10: `in_ready` equals `!out_valid || out_ready`. Results leave in operand order. Outputs hold stable while `out_valid` is high and `out_ready` is low.
- R11: After reset `out_valid` is 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Operand offered |
| in_ready | output | 1 | Operand accepted this cycle when high with in_valid |
| in_op | input | 64 | binary64 operand |
| in_rmode | input | 2 | Rounding direction |
| in_trap_en | input | 1 | Invalid-operation trap enable |
| out_valid | output | 1 | Result available |
| out_ready | input | 1 | Consumer takes the result |
| out_lo | output | 64 | Zero-extended binary16 result |
| out_hi | output | 64 | Second result word, always zero |
| out_we | output | 1 | Result and class may be written |
| out_snan | output | 1 | Invalid: signaling NaN input |
| out_ovf | output | 1 | Overflow |
| out_unf | output | 1 | Underflow |
| out_inx | output | 1 | Inexact |
| out_rup | output | 1 | Magnitude rounded up |
| out_finx | output | 1 | Inexact, masked by trap |
| out_cls | output | 5 | Result class code |

## Verification
Directed operands sit on every rounding decision point. An exact 1.0 separates the modes only through the inexact flag. The largest finite half and the overflow tie at 65520 separate saturation from infinity per direction. Ties at 2^-25 and just below 2^-14 expose round-to-even against the subnormal-to-normal carry. Quiet and signaling NaNs of both signs are run with the trap on and off, which tells a suppressed write from a normal one. Random operands clustered around the half exponent range, in all four modes, cover the ordinary normal/subnormal boundary. Random consumer stalls check ordering and output holding.

// File: rtl/dh_pkg.sv
package dh_pkg;
  localparam int DEXP_W = 11;
  localparam int DFRAC_W = 52;
  localparam int HEXP_W = 5;
  localparam int HFRAC_W = 10;
  localparam int HALF_W = 1 + HEXP_W + HFRAC_W;
  localparam int BIAS_GAP = 1023 - 15;
  localparam int HEXP_MAX = (1 << HEXP_W) - 2;

  typedef enum logic [1:0] {
    RM_NEAR = 2'b00,
    RM_ZERO = 2'b01,
    RM_UP   = 2'b10,
    RM_DOWN = 2'b11
  } rmode_e;

  localparam logic [4:0] CLS_QNAN  = 5'b10001;
  localparam logic [4:0] CLS_NINF  = 5'b01001;
  localparam logic [4:0] CLS_PINF  = 5'b00101;
  localparam logic [4:0] CLS_NNORM = 5'b01000;
  localparam logic [4:0] CLS_PNORM = 5'b00100;
  localparam logic [4:0] CLS_NSUB  = 5'b11000;
  localparam logic [4:0] CLS_PSUB  = 5'b10100;
  localparam logic [4:0] CLS_NZERO = 5'b10010;
  localparam logic [4:0] CLS_PZERO = 5'b00010;

  typedef struct packed {
    logic [HALF_W-1:0] h;
    logic snan;
    logic ovf;
    logic unf;
    logic inx;
    logic rup;
  } conv_t;
endpackage

// File: rtl/dh_round_core.sv
module dh_round_core
  import dh_pkg::*;
(
  input  logic [63:0] op,
  input  rmode_e      rm,
  output conv_t       res
);
  localparam int WV_W = 64;
  localparam int KEEP_LSB = WV_W - (HFRAC_W + 1);

  logic                sgn;
  logic [DEXP_W-1:0]   ex;
  logic [DFRAC_W-1:0]  fr;
  logic signed [12:0]  he;
  logic signed [12:0]  shw;
  logic [5:0]          sh;
  logic [WV_W-1:0]     wv, shv;
  logic                lost, g, r, st, inc, tiny, big, toinf, ovf_fin;
  logic [HFRAC_W:0]    kp;
  logic [HEXP_W-1:0]   base;
  logic [15:0]         mag;

  always_comb begin
    sgn = op[63];
    ex  = op[62:52];
    fr  = op[51:0];
    he  = $signed({2'b00, ex}) - 13'sd1008;
    tiny = (he <= 0);
    big  = (he > HEXP_MAX);
    shw  = 13'sd1 - he;
    if (!tiny)          sh = 6'd0;
    else if (he < -62)  sh = 6'd63;
    else                sh = shw[5:0];

    wv   = {(ex != '0), fr, 11'b0};
    shv  = wv >> sh;
    lost = ((shv << sh) != wv);
    kp   = shv[WV_W-1:KEEP_LSB];
    g    = shv[KEEP_LSB-1];
    r    = shv[KEEP_LSB-2];
    st   = (|shv[KEEP_LSB-3:0]) | lost;

    unique case (rm)
      RM_NEAR: inc = g & (r | st | kp[0]);
      RM_ZERO: inc = 1'b0;
      RM_UP:   inc = ~sgn & (g | r | st);
      default: inc = sgn & (g | r | st);
    endcase

    base    = (tiny || big) ? '0 : HEXP_W'(he[HEXP_W-1:0] - 5'd1);
    mag     = {1'b0, base, 10'b0} + {5'b0, kp} + {15'b0, inc};
    ovf_fin = big || (mag >= 16'h7C00);
    toinf   = (rm == RM_NEAR) || (rm == RM_UP && !sgn) || (rm == RM_DOWN && sgn);

    res = '0;
    if (ex == '1) begin
      if (fr != '0) begin
        res.h    = {sgn, 5'h1F, 1'b1, fr[50:42]};
        res.snan = ~fr[51];
      end else begin
        res.h = {sgn, 15'h7C00};
      end
    end else if (ex == '0 && fr == '0) begin
      res.h = {sgn, 15'h0000};
    end else if (ovf_fin) begin
      res.ovf = 1'b1;
      res.inx = 1'b1;
      res.rup = toinf;
      res.h   = toinf ? {sgn, 15'h7C00} : {sgn, 15'h7BFF};
    end else begin
      res.h   = {sgn, mag[14:0]};
      res.inx = g | r | st;
      res.rup = inc;
      res.unf = tiny & (g | r | st);
    end
  end
endmodule

// File: rtl/dh_classify.sv
module dh_classify
  import dh_pkg::*;
(
  input  logic [HALF_W-1:0] h,
  output logic [4:0]        cls
);
  logic              s;
  logic [HEXP_W-1:0] e;
  logic [HFRAC_W-1:0] f;

  always_comb begin
    s = h[HALF_W-1];
    e = h[HALF_W-2:HFRAC_W];
    f = h[HFRAC_W-1:0];
    if (e == '1)       cls = (f != '0) ? CLS_QNAN : (s ? CLS_NINF : CLS_PINF);
    else if (e != '0)  cls = s ? CLS_NNORM : CLS_PNORM;
    else if (f != '0)  cls = s ? CLS_NSUB : CLS_PSUB;
    else               cls = s ? CLS_NZERO : CLS_PZERO;
  end
endmodule

// File: rtl/dh_convert.sv
module dh_convert
  import dh_pkg::*;
#(
  parameter int WORD_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [63:0]       in_op,
  input  logic [1:0]        in_rmode,
  input  logic              in_trap_en,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [WORD_W-1:0] out_lo,
  output logic [WORD_W-1:0] out_hi,
  output logic              out_we,
  output logic              out_snan,
  output logic              out_ovf,
  output logic              out_unf,
  output logic              out_inx,
  output logic              out_rup,
  output logic              out_finx,
  output logic [4:0]        out_cls
);
  localparam int PAD_W = WORD_W - HALF_W;

  conv_t             cres;
  logic [4:0]        ccls;
  logic              trap, take;
  logic [HALF_W-1:0] r_h;

  dh_round_core u_core (.op(in_op), .rm(rmode_e'(in_rmode)), .res(cres));
  dh_classify   u_cls  (.h(cres.h), .cls(ccls));

  assign trap     = in_trap_en & cres.snan;
  assign in_ready = ~out_valid | out_ready;
  assign take     = in_valid & in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      r_h       <= '0;
      out_we    <= 1'b0;
      out_snan  <= 1'b0;
      out_ovf   <= 1'b0;
      out_unf   <= 1'b0;
      out_inx   <= 1'b0;
      out_rup   <= 1'b0;
      out_finx  <= 1'b0;
      out_cls   <= '0;
    end else begin
      if (take) begin
        out_valid <= 1'b1;
        r_h       <= trap ? '0 : cres.h;
        out_we    <= ~trap;
        out_snan  <= cres.snan;
        out_ovf   <= cres.ovf;
        out_unf   <= cres.unf;
        out_inx   <= cres.inx;
        out_rup   <= ~trap & cres.rup;
        out_finx  <= ~trap & cres.inx;
        out_cls   <= trap ? '0 : ccls;
      end else if (out_ready) begin
        out_valid <= 1'b0;
      end
    end
  end

  assign out_lo = {{PAD_W{1'b0}}, r_h};
  assign out_hi = '0;

  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_lo) && $stable(out_cls) && $stable(out_we));
  p_idle_ready_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> in_ready);
  p_trap_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_we |-> out_snan && out_cls == '0 && !out_rup && !out_finx && out_lo == '0);
  p_ovf_inexact_r4: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ovf |-> out_inx && out_lo[14:10] >= 5'h1E);
  p_unf_inexact_r5: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_unf |-> out_inx && out_lo[14:10] <= 5'h01);
  p_nan_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_we && out_lo[14:10] == 5'h1F && out_lo[9:0] != '0 |-> out_lo[9] && out_cls == CLS_QNAN);
  p_finx_r8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_we |-> out_finx == out_inx);
endmodule

// File: tb/dh_convert_test.sv
module dh_convert_test;
  localparam int PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [63:0] in_op = '0;
  logic [1:0]  in_rmode = '0;
  logic        in_trap_en = 1'b0;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic [63:0] out_lo, out_hi;
  logic        out_we, out_snan, out_ovf, out_unf, out_inx, out_rup, out_finx;
  logic [4:0]  out_cls;

  always #(PERIOD/2) clk = ~clk;

  dh_convert uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_op(in_op), .in_rmode(in_rmode), .in_trap_en(in_trap_en),
    .out_valid(out_valid), .out_ready(out_ready), .out_lo(out_lo), .out_hi(out_hi),
    .out_we(out_we), .out_snan(out_snan), .out_ovf(out_ovf), .out_unf(out_unf),
    .out_inx(out_inx), .out_rup(out_rup), .out_finx(out_finx), .out_cls(out_cls)
  );

  typedef struct packed {
    logic [15:0] h;
    logic snan, ovf, unf, inx, rup, finx, we;
    logic [4:0] cls;
  } exp_t;

  exp_t q[$];
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, expv);
    end
  endtask

  function automatic logic [4:0] cls_of(input logic [15:0] h);
    if (h[14:10] == 5'h1F) return (h[9:0] != 0) ? 5'b10001 : (h[15] ? 5'b01001 : 5'b00101);
    if (h[14:10] != 0)     return h[15] ? 5'b01000 : 5'b00100;
    if (h[9:0] != 0)       return h[15] ? 5'b11000 : 5'b10100;
    return h[15] ? 5'b10010 : 5'b00010;
  endfunction

  function automatic exp_t model(input logic [63:0] a, input logic [1:0] rm, input logic te);
    exp_t x;
    bit s, above, tie, nz, up, toinf, trap;
    int e, bige, qe, d;
    longint unsigned f, m, n, rem, half;
    logic [31:0] mag;
    x = '0;
    s = a[63];
    e = int'(a[62:52]);
    f = {12'b0, a[51:0]};
    if (e == 2047) begin
      if (f != 0) begin
        x.h = {s, 5'h1F, 1'b1, a[50:42]};
        x.snan = ~a[51];
      end else x.h = {s, 15'h7C00};
    end else if (e == 0 && f == 0) begin
      x.h = {s, 15'h0};
    end else begin
      m = (e != 0) ? (f | (64'd1 << 52)) : f;
      bige = (e != 0) ? e - 1023 : -1022;
      qe = ((bige < -14) ? -14 : bige) - 10;
      d = qe - (bige - 52);
      if (d >= 60) begin
        n = 0; rem = m; half = 64'd1 << 59;
      end else begin
        n = m >> d; rem = m - (n << d); half = 64'd1 << (d - 1);
      end
      above = rem > half; tie = rem == half; nz = rem != 0;
      case (rm)
        2'b00:   up = above | (tie & n[0]);
        2'b01:   up = 1'b0;
        2'b10:   up = !s && nz;
        default: up = s && nz;
      endcase
      if (bige > 15) mag = 32'hFFFF;
      else if (bige < -14) mag = 32'(n) + 32'(up);
      else mag = 32'((bige + 15) << 10) + 32'(n) + 32'(up) - 32'd1024;
      if (mag >= 32'h7C00) begin
        x.ovf = 1'b1; x.inx = 1'b1;
        toinf = (rm == 2'b00) || (rm == 2'b10 && !s) || (rm == 2'b11 && s);
        x.h = toinf ? {s, 15'h7C00} : {s, 15'h7BFF};
        x.rup = toinf;
      end else begin
        x.h = {s, mag[14:0]};
        x.inx = nz; x.rup = up;
        x.unf = (bige < -14) && nz;
      end
    end
    trap = te && x.snan;
    x.we = ~trap;
    if (trap) begin x.h = '0; x.rup = 1'b0; end
    x.finx = ~trap & x.inx;
    x.cls = trap ? 5'b0 : cls_of(x.h);
    return x;
  endfunction

  task automatic cycle(input bit vld, input logic [63:0] op, input logic [1:0] rm,
                       input logic te, input bit rdy, output bit acc);
    exp_t ex;
    bit rdy_model;
    @(negedge clk);
    chk(out_valid == (q.size() != 0), "R10 out_valid", 64'(out_valid), 64'(q.size() != 0));
    if (q.size() != 0 && out_valid) begin
      ex = q[0];
      chk(out_lo[15:0] == ex.h, "R1 result", out_lo, 64'(ex.h));
      chk(out_lo[63:16] == 0 && out_hi == 0, "R2 zero words", out_hi | {out_lo[63:16], 16'h0}, 64'h0);
      chk(out_snan == ex.snan, "R3 snan flag", 64'(out_snan), 64'(ex.snan));
      chk(out_ovf == ex.ovf, "R4 overflow", 64'(out_ovf), 64'(ex.ovf));
      chk(out_inx == ex.inx, "R1 inexact", 64'(out_inx), 64'(ex.inx));
      chk(out_unf == ex.unf, "R5 underflow", 64'(out_unf), 64'(ex.unf));
      chk(out_we == ex.we, "R6 write enable", 64'(out_we), 64'(ex.we));
      chk(out_rup == ex.rup, "R7 rounded up", 64'(out_rup), 64'(ex.rup));
      chk(out_finx == ex.finx, "R8 fraction inexact", 64'(out_finx), 64'(ex.finx));
      chk(out_cls == ex.cls, "R9 class", 64'(out_cls), 64'(ex.cls));
    end
    in_valid = vld; in_op = op; in_rmode = rm; in_trap_en = te; out_ready = rdy;
    #1;
    rdy_model = (q.size() == 0) || rdy;
    chk(in_ready == rdy_model, "R10 in_ready", 64'(in_ready), 64'(rdy_model));
    if (q.size() != 0 && rdy) void'(q.pop_front());
    acc = vld && rdy_model;
    if (acc) q.push_back(model(op, rm, te));
  endtask

  task automatic send(input logic [63:0] op, input logic [1:0] rm, input logic te);
    bit acc;
    do cycle(1'b1, op, rm, te, ($urandom_range(0, 3) != 0), acc); while (!acc);
  endtask

  logic [63:0] dir [14] = '{
    64'h3FF0000000000000, 64'h40EFFC0000000000, 64'h40EFFE0000000000,
    64'h3E70000000000000, 64'h3E60000000000000, 64'h3E60000000000001,
    64'h3F0FFE0000000000, 64'h7FF8000000000000, 64'h7FF0000000000001,
    64'hFFF4000000000000, 64'hFFF0000000000000, 64'h8000000000000000,
    64'h0000000000000001, 64'hC0F0000000000000
  };

  initial begin
    bit acc;
    logic [63:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk(out_valid == 1'b0, "R11 reset valid", 64'(out_valid), 64'h0);
    chk(in_ready == 1'b1, "R11 reset ready", 64'(in_ready), 64'h1);
    for (int i = 0; i < 14; i++)
      for (int rm = 0; rm < 4; rm++)
        for (int te = 0; te < 2; te++)
          send(dir[i], 2'(rm), te[0]);
    for (int i = 0; i < 4000; i++) begin
      v = {$urandom, $urandom};
      case ($urandom_range(0, 7))
        0:       ;
        1:       v[62:52] = 11'h7FF;
        default: v[62:52] = 11'(985 + $urandom_range(0, 50));
      endcase
      if ($urandom_range(0, 5) == 0) cycle(1'b0, '0, 2'b00, 1'b0, 1'b1, acc);
      send(v, 2'($urandom_range(0, 3)), 1'($urandom_range(0, 1)));
    end
    repeat (4) cycle(1'b0, '0, 2'b00, 1'b0, 1'b1, acc);
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #(PERIOD * 150000);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL R10 watchdog actual=%h expected=%h", 64'h1, 64'h0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule